// File: doc/BRIEF.md
# Symmetric Transposed-Form FIR Filter

This block is a 73-tap finite impulse response filter with constant coefficients. It accepts a stream of 32-bit signed samples and returns a stream of 32-bit signed filtered results, one per accepted sample. Both streams use a valid/ready handshake. Internally the filter is in transposed form. Each accepted sample is scaled by every coefficient in the same cycle, and the products are summed into a chain of registered partial sums.

The coefficient set is symmetric about the centre tap, so only the 37 coefficients of the lower half (indices 0 to 36) are given as a parameter. Each distinct product is formed once and feeds both mirrored positions of the chain. The implementation of each product is chosen at elaboration time from the coefficient value:

- A zero coefficient contributes nothing.
- A coefficient whose magnitude is a single power of two, or the sum or difference of two powers of two, is built from shifts and adds.
- Every other coefficient uses a multiplier.

Top module: `fir_sym73`

## Requirements
- R1: After each accepted sample x(n), the result is y(n) = sum over k = 0..72 of a[k]*x(n-k). Here a[k] = COEF[k] for k <= 36 and a[k] = COEF[72-k] otherwise. The output is the low 32 bits of the exact sum, in two's complement.
- R2: While rst_ni is low, out_valid_o is 0 and every partial sum is cleared, asynchronously. After release, the input history behaves as all zeros.
- R3: A sample is accepted exactly when in_valid_i and in_ready_o are both 1 at a rising clock edge. Each accepted sample produces exactly one result, with out_valid_o high from the following cycle.
- R4: in_ready_o is 1 when out_valid_o is 0 or out_ready_i is 1, and is 0 otherwise.
- R5: While out_valid_o is 1 and out_ready_i is 0, the following hold: out_valid_o stays 1, out_data_o holds its value, and the partial-sum chain does not advance.
- R6: When a result is taken (out_valid_o and out_ready_i both 1) and no sample is accepted in that cycle, out_valid_o is 0 in the next cycle.
- R7: A coefficient of zero (the default table has one at index 31, mirrored at 41) adds nothing. The impulse response is 0 at those positions.
- R8: The shift-add coefficients of the default table give exact products for all inputs, including -2^31: 384 at index 4, -15 at index 8, 20 at index 14 and -6 at index 27.
- R9: Inputs at the 32-bit extremes give results that wrap modulo 2^32 and match the exact sum reduced to 32 bits.
- R10: With out_ready_i held at 1, the block accepts a sample in every cycle, and in_ready_o stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block can accept a sample |
| in_data_i | input | 32 | Input sample, signed |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream takes the result |
| out_data_o | output | 32 | Filtered result, signed |

## Verification
The two events that can coincide are taking a held result at the output and accepting a new sample at the input. When both happen in one cycle, the output register must reload with the new result and must not drop to empty. A scenario drives in_valid_i and out_ready_i from independent pseudo-random bits, so this overlap is provoked repeatedly alongside stalls and idle cycles. The scenario counts the overlap cycles. Every result is compared, in order, against a direct-form model that is updated only on observed input handshakes, so a lost, repeated or misplaced result shows up as a mismatch.

// File: rtl/fir_sym_pkg.sv
`timescale 1ns/1ps
package fir_sym_pkg;
  localparam int TAPS_DEF = 73;
  localparam int XW_DEF   = 32;
  localparam int CW_DEF   = 16;
  localparam int NU_DEF   = (TAPS_DEF + 1) / 2;

  localparam logic signed [CW_DEF-1:0] COEF_DEFAULT [NU_DEF] = '{
    -16'sd11,   16'sd13,  -16'sd19,   16'sd21,  16'sd384,  -16'sd23,   16'sd25,  -16'sd27,
    -16'sd15,   16'sd29,  -16'sd37,   16'sd43,  -16'sd45,   16'sd53,   16'sd20,  -16'sd75,
     16'sd91,  -16'sd105,  16'sd117, -16'sd150,  16'sd211, -16'sd300,  16'sd555, -16'sd613,
     16'sd709, -16'sd811,  16'sd917,  -16'sd6, -16'sd1019, 16'sd1131, -16'sd1237,  16'sd0,
     16'sd1453,-16'sd1877, 16'sd2345, 16'sd3011, 16'sd4123
  };

  typedef enum logic [1:0] {IMPL_ZERO, IMPL_SHADD, IMPL_MULT} impl_e;

  typedef struct packed {
    impl_e      impl;
    logic       neg;
    logic       sub;
    logic       two;
    logic [4:0] sh_hi;
    logic [4:0] sh_lo;
  } impl_t;

  // |c| == 2^a, 2^a + 2^b or 2^a - 2^b -> shift-add, else multiplier
  function automatic impl_t pick_impl(int c, int cw);
    impl_t r;
    int    m;
    bit    found;
    r       = '0;
    r.impl  = IMPL_MULT;
    found   = 1'b0;
    if (c == 0) begin
      r.impl = IMPL_ZERO;
      found  = 1'b1;
    end
    m     = (c < 0) ? -c : c;
    r.neg = (c < 0);
    for (int a = 0; a <= cw; a++) begin
      if (!found && m == (1 << a)) begin
        r.impl  = IMPL_SHADD;
        r.sh_hi = 5'(a);
        found   = 1'b1;
      end
    end
    for (int a = 1; a <= cw; a++) begin
      for (int b = 0; b < a; b++) begin
        if (!found && m == ((1 << a) + (1 << b))) begin
          r.impl = IMPL_SHADD; r.two = 1'b1; r.sub = 1'b0;
          r.sh_hi = 5'(a); r.sh_lo = 5'(b); found = 1'b1;
        end
        if (!found && m == ((1 << a) - (1 << b))) begin
          r.impl = IMPL_SHADD; r.two = 1'b1; r.sub = 1'b1;
          r.sh_hi = 5'(a); r.sh_lo = 5'(b); found = 1'b1;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/fir_const_mult.sv
`timescale 1ns/1ps
module fir_const_mult #(
  parameter int XW = 32,
  parameter int CW = 16,
  parameter int PW = 56,
  parameter int C  = 1
) (
  input  logic signed [XW-1:0] x_i,
  output logic signed [PW-1:0] p_o
);
  import fir_sym_pkg::*;

  localparam impl_t IMPL  = pick_impl(C, CW);
  localparam int    SH_HI = int'(IMPL.sh_hi);
  localparam int    SH_LO = int'(IMPL.sh_lo);

  logic signed [PW-1:0] x_ext;
  assign x_ext = PW'(x_i);

  generate
    if (IMPL.impl == IMPL_SHADD) begin : g_shadd
      logic signed [PW-1:0] hi, lo, mag;
      assign hi = x_ext <<< SH_HI;
      if (IMPL.two) begin : g_two
        assign lo = x_ext <<< SH_LO;
      end else begin : g_one
        assign lo = '0;
      end
      assign mag = IMPL.sub ? (hi - lo) : (hi + lo);
      assign p_o = IMPL.neg ? -mag : mag;
    end else begin : g_mult
      localparam logic signed [PW-1:0] CVAL = PW'(C);
      assign p_o = x_ext * CVAL;
    end
  endgenerate
endmodule

// File: rtl/fir_tap_chain.sv
`timescale 1ns/1ps
module fir_tap_chain #(
  parameter int TAPS = 73,
  parameter int XW   = 32,
  parameter int PW   = 56,
  localparam int NU  = (TAPS + 1) / 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic signed [PW-1:0] prod_i [NU],
  output logic        [XW-1:0] y_o
);
  logic signed [PW-1:0] sum_q [1:TAPS-1];
  logic signed [PW-1:0] y_full;
  logic        [PW-XW-1:0] unused_hi;

  // position k uses the product of its mirror-folded index
  for (genvar k = 1; k < TAPS; k++) begin : g_stage
    localparam int M = (k < NU) ? k : (TAPS - 1 - k);
    logic signed [PW-1:0] nxt;
    if (k == TAPS - 1) begin : g_last
      assign nxt = prod_i[M];
    end else begin : g_mid
      assign nxt = sum_q[k+1] + prod_i[M];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sum_q[k] <= '0;
      else if (adv_i) sum_q[k] <= nxt;
    end
  end

  assign y_full    = prod_i[0] + sum_q[1];
  assign y_o       = y_full[XW-1:0];
  assign unused_hi = y_full[PW-1:XW];

  p_chain_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(sum_q[1]) && $stable(sum_q[TAPS-1]));
endmodule

// File: rtl/fir_out_stage.sv
`timescale 1ns/1ps
module fir_out_stage #(
  parameter int XW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [XW-1:0] data_i,
  input  logic          out_ready_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [XW-1:0] out_data_o
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (acc_i) begin
      out_valid_o <= 1'b1;
      out_data_o  <= data_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  p_accept_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> out_valid_o);

  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  p_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !acc_i |=> !out_valid_o);
endmodule

// File: rtl/fir_sym73.sv
`timescale 1ns/1ps
module fir_sym73 #(
  parameter int TAPS = fir_sym_pkg::TAPS_DEF,
  parameter int XW   = fir_sym_pkg::XW_DEF,
  parameter int CW   = fir_sym_pkg::CW_DEF,
  parameter logic signed [CW-1:0] COEF [(TAPS+1)/2] = fir_sym_pkg::COEF_DEFAULT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [XW-1:0] in_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [XW-1:0] out_data_o
);
  localparam int NU = (TAPS + 1) / 2;
  localparam int PW = XW + CW + $clog2(TAPS) + 1;

  logic                 accept;
  logic signed [PW-1:0] prod [NU];
  logic        [XW-1:0] y_next;

  assign accept = in_valid_i && in_ready_o;

  for (genvar j = 0; j < NU; j++) begin : g_prod
    if (COEF[j] == 0) begin : g_zero
      assign prod[j] = '0;
    end else begin : g_cm
      fir_const_mult #(
        .XW(XW), .CW(CW), .PW(PW), .C(int'(COEF[j]))
      ) u_cm (
        .x_i (in_data_i),
        .p_o (prod[j])
      );
    end
  end

  fir_tap_chain #(.TAPS(TAPS), .XW(XW), .PW(PW)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (accept),
    .prod_i (prod),
    .y_o    (y_next)
  );

  fir_out_stage #(.XW(XW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (accept),
    .data_i      (y_next),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );
endmodule

// File: tb/fir_sym73_test.sv
`timescale 1ns/1ps
module fir_sym73_test;
  localparam int TAPS = 73;
  localparam int NU   = 37;
  localparam logic signed [15:0] TB_COEF [NU] = '{
    -16'sd11,   16'sd13,  -16'sd19,   16'sd21,  16'sd384,  -16'sd23,   16'sd25,  -16'sd27,
    -16'sd15,   16'sd29,  -16'sd37,   16'sd43,  -16'sd45,   16'sd53,   16'sd20,  -16'sd75,
     16'sd91,  -16'sd105,  16'sd117, -16'sd150,  16'sd211, -16'sd300,  16'sd555, -16'sd613,
     16'sd709, -16'sd811,  16'sd917,  -16'sd6, -16'sd1019, 16'sd1131, -16'sd1237,  16'sd0,
     16'sd1453,-16'sd1877, 16'sd2345, 16'sd3011, 16'sd4123
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int     checks = 0;
  int     errors = 0;
  string  tag = "R2";
  bit     done = 1'b0;
  int     overlap_cnt = 0;
  longint hist [TAPS];
  int     exp_q [$];
  logic [31:0] lfsr = 32'h1234_abcd;

  always #2.5 clk = ~clk;

  fir_sym73 #(.COEF(TB_COEF)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  function automatic longint coef_at(int k);
    return (k < NU) ? longint'(TB_COEF[k]) : longint'(TB_COEF[TAPS-1-k]);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    exp_q.delete();
  endtask

  task automatic model_push(logic [31:0] x);
    longint s;
    for (int i = TAPS-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = longint'($signed(x));
    s = 0;
    for (int k = 0; k < TAPS; k++) s += coef_at(k) * hist[k];
    exp_q.push_back(int'(s[31:0]));
  endtask

  function automatic logic [31:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // scoreboard: output handshake first, then input handshake
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, tag, "unexpected result", longint'($signed(out_data)), 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check($signed(out_data) == e, tag, "result", longint'($signed(out_data)), e);
        end
      end
      if (in_valid && in_ready && out_valid && out_ready) overlap_cnt++;
      if (in_valid && in_ready) model_push(in_data);
    end
  end

  task automatic drive(bit v, logic [31:0] d, bit r);
    @(posedge clk); #1;
    in_valid = v; in_data = d; out_ready = r;
  endtask

  task automatic drain_and_check(string req);
    for (int i = 0; i < 4; i++) drive(1'b0, '0, 1'b1);
    @(negedge clk);
    check(exp_q.size() == 0, req, "pending results", exp_q.size(), 0);
  endtask

  task automatic t_reset();
    tag = "R2";
    rst_n = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R4", "in_ready when empty", in_ready, 1);
    model_clear();
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_impulse();
    tag = "R1 R7 R8";
    drive(1'b1, 32'd1, 1'b1);
    for (int i = 0; i < TAPS + 2; i++) drive(1'b1, 32'd0, 1'b1);
    drive(1'b1, 32'h8000_0000, 1'b1);
    for (int i = 0; i < TAPS + 2; i++) drive(1'b1, 32'd0, 1'b1);
    drain_and_check("R1");
  endtask

  task automatic t_wrap();
    tag = "R9";
    for (int i = 0; i < 80; i++) drive(1'b1, 32'h7fff_ffff, 1'b1);
    for (int i = 0; i < 80; i++) drive(1'b1, 32'h8000_0000, 1'b1);
    for (int i = 0; i < 40; i++) drive(1'b1, (i % 2) ? 32'h8000_0000 : 32'h7fff_ffff, 1'b1);
    drain_and_check("R9");
  endtask

  task automatic t_stream();
    tag = "R10 R1";
    for (int i = 0; i < 200; i++) begin
      drive(1'b1, next_rand(), 1'b1);
      @(negedge clk);
      check(in_ready == 1'b1, "R10", "in_ready in stream", in_ready, 1);
    end
    drain_and_check("R10");
  endtask

  task automatic t_stall();
    logic [31:0] held;
    tag = "R5";
    drive(1'b1, 32'd777, 1'b1);
    drive(1'b1, 32'hffff_fff0, 1'b0);
    @(negedge clk);
    held = out_data;
    check(out_valid == 1'b1, "R5", "out_valid at stall", out_valid, 1);
    check(in_ready == 1'b0, "R4", "in_ready at stall", in_ready, 0);
    for (int i = 0; i < 5; i++) begin
      drive(1'b1, next_rand(), 1'b0);
      @(negedge clk);
      check(out_data == held, "R5", "held data", longint'(out_data), longint'(held));
      check(in_ready == 1'b0, "R4", "in_ready while stalled", in_ready, 0);
    end
    drive(1'b1, 32'd31, 1'b1);
    drain_and_check("R5");
  endtask

  task automatic t_drain();
    tag = "R6";
    drive(1'b1, 32'd5, 1'b0);
    drive(1'b0, 32'd0, 1'b0);
    drive(1'b0, 32'd0, 1'b1);
    drive(1'b0, 32'd0, 1'b0);
    @(negedge clk);
    check(out_valid == 1'b0, "R6", "out_valid after take", out_valid, 0);
    drain_and_check("R6");
  endtask

  task automatic t_overlap();
    logic [31:0] r;
    tag = "R3";
    overlap_cnt = 0;
    for (int i = 0; i < 300; i++) begin
      r = next_rand();
      drive(r[3], next_rand(), r[9] | r[20]);
    end
    drain_and_check("R3");
    check(overlap_cnt > 0, "R3", "overlap cycles seen", overlap_cnt, 1);
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 10; i++) drive(1'b1, next_rand(), 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    model_clear();
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "out_valid on reset", out_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    tag = "R2";
    drive(1'b1, 32'd3, 1'b1);
    for (int i = 0; i < 12; i++) drive(1'b1, 32'd0, 1'b1);
    drain_and_check("R2");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    model_clear();
    t_reset();
    t_impulse();
    t_wrap();
    t_stream();
    t_stall();
    t_drain();
    t_overlap();
    t_reset_mid();
    finish_run();
  end
endmodule